// File: doc/BRIEF.md
# Single-Wire Bus Slave Interface

This block is the device-side front end of a one-wire, open-drain bus with a pull-up. It samples the shared line through a synchroniser and times how long the line stays low. A long low resets the slave, and the slave answers it with a presence pulse. A medium low aborts whatever transfer is in progress. After presence, the host starts every bit slot with a short low strobe. In write slots the slave samples the level to get a bit. In read slots the slave returns a bit by pulling the line low for a 0 or leaving it released for a 1. Every timing value is a parameter counted in system-clock cycles.

The first byte after presence is a command byte. When it equals the profile code (0x99), the slave returns the acknowledge byte 0x55 over the next eight read slots and then enters a data phase. Any other code sends the slave to an idle state, where it ignores slots until the next bus reset. In the data phase, write slots assemble bytes for the rest of the device, and each completed byte is reported on `rx_byte` with a one-cycle `rx_valid` strobe. The device can queue one byte with `tx_load`, which turns the next eight slots into read slots that return that byte.

The controller has eight states. ST_IDLE waits for a long low. ST_LONG_LOW waits for the line to be released. ST_PRES_WAIT is the presence delay, ST_PRES_DRIVE is the presence pulse, and ST_RECOVER is the recovery gap. ST_SLOT_WAIT waits for a host strobe. ST_WSLOT samples a written bit and ST_RSLOT returns a read bit.

The transitions are as follows. Any state moves to ST_LONG_LOW when the low count reaches T_ABORT, except ST_PRES_DRIVE, where the low count is held at zero. On release, ST_LONG_LOW goes to ST_PRES_WAIT if the low lasted T_RESET cycles, and to ST_IDLE otherwise. The presence states follow each other on their cycle counts: ST_PRES_WAIT to ST_PRES_DRIVE, ST_PRES_DRIVE to ST_RECOVER, and ST_RECOVER to ST_SLOT_WAIT. ST_SLOT_WAIT goes to ST_RSLOT or ST_WSLOT on a falling edge, depending on the phase. ST_WSLOT returns to ST_SLOT_WAIT after sampling once the line is high, or goes to ST_IDLE if the command byte was wrong. ST_RSLOT returns to ST_SLOT_WAIT after T_RHOLD cycles.

Top module: `swb_slave`

## Requirements
- R1: After `rst_n` is deasserted, `drive_low` and `rx_valid` are 0, and until the first bus reset the slave ignores write slots, so `rx_valid` never pulses.
- R2: When the line has been low for at least T_RESET cycles and is then released, the slave waits about T_PDLY cycles (plus up to 4 cycles of synchroniser delay) and then holds `drive_low` high for exactly T_PP cycles.
- R3: A low lasting between T_ABORT and T_RESET cycles aborts any transfer and produces no presence pulse. The slave then ignores write slots until the next bus reset.
- R4: In a write slot, the line is sampled T_SAMP cycles after the strobe is seen: low gives 0 and high gives 1. Bits are assembled least-significant first, and each eighth bit raises `rx_valid` for exactly one cycle with the byte on `rx_byte`.
- R5: If the command byte (the first byte after presence) is 0x99, the next eight slots are read slots that return 0x55 LSB first. In each of them, `drive_low` is high for T_RHOLD cycles when the bit is 0.
- R6: Any other command byte is still strobed on `rx_byte`. The slave then drives nothing in later slots, so reads return 0xFF, and it strobes no further bytes until the next bus reset.
- R7: After the acknowledge byte, every group of eight write slots produces one strobed byte.
- R8: A `tx_load` pulse in the data phase, at a byte boundary and with no byte pending, queues `tx_data`. The next eight slots return that byte LSB first, and the slave then goes back to write slots. A `tx_load` while a byte is pending is ignored.
- R9: `drive_low` is high only during the presence pulse and during read slots that carry a 0. It is never high during a write slot or while the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Sampled level of the shared bus wire |
| drive_low | output | 1 | Registered request to pull the wire low |
| rx_byte | output | DW | Last byte received from write slots |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |
| tx_data | input | DW | Byte to return in read slots |
| tx_load | input | 1 | Queue `tx_data` for transmission |

## Verification
The bench targets these corner cases:
- A low just long enough to abort but too short to reset. A slave that confused the two thresholds would pulse presence, or would go on accepting bytes.
- A reset that arrives in the middle of a byte. A stale bit counter would then corrupt the next command.
- A wrong command code. If the slave did not go quiet, it would keep strobing bytes or pull the line during read slots.
- A second `tx_load` while a byte is already pending. If the slave accepted it, the returned byte would be wrong.
- All-zero and all-one data bytes in both directions, to catch bit-order and slot-type mistakes.

// File: rtl/swb_pkg.sv
package swb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LONG_LOW,
        ST_PRES_WAIT,
        ST_PRES_DRIVE,
        ST_RECOVER,
        ST_SLOT_WAIT,
        ST_WSLOT,
        ST_RSLOT
    } swb_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ACK,
        PH_DATA
    } swb_phase_e;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic fell,
    output logic rose
);
    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '1;
            prev <= 1'b1;
        end else begin
            sr   <= {sr[STAGES-2:0], line_raw};
            prev <= sr[STAGES-1];
        end
    end

    assign line_s = sr[STAGES-1];
    assign fell   = prev & ~line_s;
    assign rose   = ~prev & line_s;
endmodule

// File: rtl/swb_lowtimer.sv
module swb_lowtimer #(
    parameter int T_ABORT = 60,
    parameter int T_RESET = 240,
    parameter int CW      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic hold_clr,
    output logic abort_hit,
    output logic reset_len
);
    localparam logic [CW-1:0] A_LIM = CW'(T_ABORT);
    localparam logic [CW-1:0] R_LIM = CW'(T_RESET);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold_clr || line_s) begin
            cnt <= '0;
        end else if (cnt != R_LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign abort_hit = (cnt == A_LIM);
    assign reset_len = (cnt == R_LIM);
endmodule

// File: rtl/swb_slave.sv
module swb_slave
    import swb_pkg::*;
#(
    parameter int          DW          = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          T_ABORT     = 60,
    parameter int          T_RESET     = 240,
    parameter int          T_PDLY      = 20,
    parameter int          T_PP        = 80,
    parameter int          T_REC       = 10,
    parameter int          T_SAMP      = 20,
    parameter int          T_RHOLD     = 30,
    parameter logic [7:0]  CMD_PROFILE = 8'h99,
    parameter logic [7:0]  ACK_BYTE    = 8'h55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    output logic          drive_low,
    output logic [DW-1:0] rx_byte,
    output logic          rx_valid,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_load
);
    localparam int CW = $clog2(T_RESET + 2);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] L_PDLY  = CW'(T_PDLY - 1);
    localparam logic [CW-1:0] L_PP    = CW'(T_PP - 1);
    localparam logic [CW-1:0] L_REC   = CW'(T_REC - 1);
    localparam logic [CW-1:0] L_SAMP  = CW'(T_SAMP);
    localparam logic [CW-1:0] L_RHOLD = CW'(T_RHOLD - 1);
    localparam logic [BW-1:0] L_LAST  = BW'(DW - 1);

    swb_state_e    st, st_nx;
    swb_phase_e    ph;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] bitcnt;
    logic [DW-1:0] rxsh, txsh, smp_byte;
    logic          pending;
    logic          line_s, fell, rose;
    logic          abort_hit, reset_len;
    logic          rd_slot, last_bit, drive_q, rxv_q;
    logic [DW-1:0] rxb_q;

    swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_in),
        .line_s   (line_s),
        .fell     (fell),
        .rose     (rose)
    );

    swb_lowtimer #(.T_ABORT(T_ABORT), .T_RESET(T_RESET), .CW(CW)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .hold_clr  (st == ST_PRES_DRIVE),
        .abort_hit (abort_hit),
        .reset_len (reset_len)
    );

    assign smp_byte = {line_s, rxsh[DW-1:1]};
    assign last_bit = (bitcnt == L_LAST);
    assign rd_slot  = (ph == PH_ACK) || (ph == PH_DATA && pending);

    // next-state logic
    always_comb begin
        st_nx = st;
        if (abort_hit && st != ST_LONG_LOW) begin
            st_nx = ST_LONG_LOW;
        end else begin
            unique case (st)
                ST_IDLE:       st_nx = ST_IDLE;
                ST_LONG_LOW:   if (rose) st_nx = reset_len ? ST_PRES_WAIT : ST_IDLE;
                ST_PRES_WAIT:  if (tcnt == L_PDLY) st_nx = ST_PRES_DRIVE;
                ST_PRES_DRIVE: if (tcnt == L_PP) st_nx = ST_RECOVER;
                ST_RECOVER:    if (tcnt == L_REC) st_nx = ST_SLOT_WAIT;
                ST_SLOT_WAIT:  if (fell) st_nx = rd_slot ? ST_RSLOT : ST_WSLOT;
                ST_WSLOT: begin
                    if (tcnt == L_SAMP && last_bit && ph == PH_CMD
                        && smp_byte != DW'(CMD_PROFILE))
                        st_nx = ST_IDLE;
                    else if (tcnt > L_SAMP && line_s)
                        st_nx = ST_SLOT_WAIT;
                end
                ST_RSLOT:      if (tcnt == L_RHOLD) st_nx = ST_SLOT_WAIT;
                default:       st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ph      <= PH_CMD;
            tcnt    <= '0;
            bitcnt  <= '0;
            rxsh    <= '0;
            txsh    <= '1;
            pending <= 1'b0;
        end else begin
            st <= st_nx;
            if (st_nx != st)    tcnt <= '0;
            else if (tcnt != '1) tcnt <= tcnt + 1'b1;

            if (st == ST_WSLOT && tcnt == L_SAMP) begin
                rxsh <= smp_byte;
                if (last_bit) begin
                    bitcnt <= '0;
                    if (ph == PH_CMD && smp_byte == DW'(CMD_PROFILE)) begin
                        ph   <= PH_ACK;
                        txsh <= DW'(ACK_BYTE);
                    end
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end

            if (st == ST_RSLOT && tcnt == L_RHOLD) begin
                txsh <= {1'b1, txsh[DW-1:1]};
                if (last_bit) begin
                    bitcnt <= '0;
                    if (ph == PH_ACK) ph <= PH_DATA;
                    else              pending <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end

            if (tx_load && st == ST_SLOT_WAIT && ph == PH_DATA
                && !pending && bitcnt == '0) begin
                txsh    <= tx_data;
                pending <= 1'b1;
            end

            if (st_nx == ST_IDLE || st_nx == ST_LONG_LOW || st_nx == ST_PRES_WAIT) begin
                ph      <= PH_CMD;
                pending <= 1'b0;
                bitcnt  <= '0;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            rxv_q   <= 1'b0;
            rxb_q   <= '0;
        end else begin
            drive_q <= (st_nx == ST_PRES_DRIVE) || (st_nx == ST_RSLOT && !txsh[0]);
            rxv_q   <= (st == ST_WSLOT && tcnt == L_SAMP && last_bit);
            if (st == ST_WSLOT && tcnt == L_SAMP && last_bit) rxb_q <= smp_byte;
        end
    end

    assign drive_low = drive_q;
    assign rx_valid  = rxv_q;
    assign rx_byte   = rxb_q;
endmodule

// File: rtl/swb_slave_chk.sv
module swb_slave_chk
    import swb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input swb_state_e st,
    input logic       drive_low,
    input logic       rx_valid,
    input logic       abort_hit,
    input logic       reset_len,
    input logic       rose
);
    assert_drive_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (st == ST_PRES_DRIVE || st == ST_RSLOT));

    assert_rx_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> (st == ST_LONG_LOW));

    assert_presence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LONG_LOW && rose && reset_len) |=> (st == ST_PRES_WAIT));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> !drive_low);
endmodule

bind swb_slave swb_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .drive_low (drive_low),
    .rx_valid  (rx_valid),
    .abort_hit (abort_hit),
    .reset_len (reset_len),
    .rose      (rose)
);

// File: tb/sim_swb_slave.sv
module sim_swb_slave;
    localparam int T_ABORT = 60;
    localparam int T_RESET = 240;
    localparam int T_PDLY  = 20;
    localparam int T_PP    = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       drive_low, rx_valid;
    logic [7:0] rx_byte;
    wire        line = !(host_low || drive_low);

    int checks = 0, errors = 0, rx_count = 0, wr_drive = 0;
    logic [7:0] rx_last = 8'h00;
    logic in_write = 1'b0;
    bit done = 1'b0;

    swb_slave #(.T_ABORT(T_ABORT), .T_RESET(T_RESET), .T_PDLY(T_PDLY), .T_PP(T_PP)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line), .drive_low(drive_low),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_data(tx_data), .tx_load(tx_load)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_count++;
            rx_last = rx_byte;
        end
        if (in_write && drive_low) wr_drive++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_reset(input int lowlen, output int pdelay, output int plen);
        @(negedge clk);
        host_low = 1'b1;
        wait_cyc(lowlen);
        host_low = 1'b0;
        pdelay = -1;
        plen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!line) begin
                if (pdelay < 0) pdelay = i;
                plen++;
            end
        end
    endtask

    task automatic write_bit(input bit b);
        in_write = 1'b1;
        host_low = 1'b1;
        wait_cyc(5);
        if (b) host_low = 1'b0;
        wait_cyc(40);
        host_low = 1'b0;
        wait_cyc(15);
        in_write = 1'b0;
    endtask

    task automatic read_bit(output bit b);
        host_low = 1'b1;
        wait_cyc(3);
        host_low = 1'b0;
        wait_cyc(12);
        b = line;
        wait_cyc(35);
    endtask

    task automatic write_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) write_bit(d[i]);
    endtask

    task automatic read_byte(output logic [7:0] d);
        bit b;
        for (int i = 0; i < 8; i++) begin
            read_bit(b);
            d[i] = b;
        end
    endtask

    task automatic pulse_load(input logic [7:0] d);
        @(negedge clk);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    function automatic logic [7:0] other_cmd(input logic [7:0] r);
        return (r == 8'h99) ? 8'h98 : r;
    endfunction

    function automatic bit pres_ok(input int pdelay, input int plen);
        return pdelay >= T_PDLY && pdelay <= T_PDLY + 4 && plen >= T_PP - 1 && plen <= T_PP + 1;
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        int pd, pl, n0;
        logic [7:0] d, d2, got;
        void'($urandom(32'd2024));
        wait_cyc(4);
        chk(drive_low == 1'b0, "R1", "drive_low in reset", drive_low, 0);
        chk(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        write_byte(8'hA5);
        chk(rx_count == 0, "R1", "bytes before bus reset", rx_count, 0);

        host_reset(300, pd, pl);
        chk(pres_ok(pd, pl), "R2", "presence delay/len", pd * 1000 + pl, T_PDLY * 1000 + T_PP);

        n0 = rx_count;
        write_byte(8'h99);
        chk(rx_count == n0 + 1, "R4", "command strobe count", rx_count - n0, 1);
        chk(rx_last == 8'h99, "R4", "command byte", rx_last, 8'h99);
        read_byte(got);
        chk(got == 8'h55, "R5", "acknowledge byte", got, 8'h55);

        for (int k = 0; k < 6; k++) begin
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
            n0 = rx_count;
            write_byte(d);
            chk(rx_count == n0 + 1 && rx_last == d, "R7", "data byte", rx_last, d);
        end

        for (int k = 0; k < 3; k++) begin
            d = (k == 0) ? 8'h00 : 8'($urandom);
            d2 = ~d;
            pulse_load(d);
            pulse_load(d2);
            read_byte(got);
            chk(got == d, "R8", "queued byte returned", got, d);
            d = 8'($urandom);
            write_byte(d);
            chk(rx_last == d, "R8", "writes resume after send", rx_last, d);
        end
        chk(wr_drive == 0, "R9", "drive during write slots", wr_drive, 0);

        host_reset(100, pd, pl);
        chk(pd < 0, "R3", "presence after short low", pl, 0);
        n0 = rx_count;
        write_byte(8'h3C);
        chk(rx_count == n0, "R3", "bytes after abort", rx_count - n0, 0);

        host_reset(300, pd, pl);
        chk(pres_ok(pd, pl), "R2", "presence after abort", pd * 1000 + pl, T_PDLY * 1000 + T_PP);
        d = other_cmd(8'($urandom));
        write_byte(d);
        chk(rx_last == d, "R6", "wrong command strobed", rx_last, d);
        read_byte(got);
        chk(got == 8'hFF, "R6", "reads after wrong command", got, 8'hFF);
        n0 = rx_count;
        write_byte(8'h99);
        chk(rx_count == n0, "R6", "bytes after wrong command", rx_count - n0, 0);

        host_reset(T_RESET + 10, pd, pl);
        chk(pres_ok(pd, pl), "R2", "presence at threshold", pd * 1000 + pl, T_PDLY * 1000 + T_PP);
        write_bit(1'b1);
        write_bit(1'b0);
        write_bit(1'b0);
        host_reset(300, pd, pl);
        chk(pres_ok(pd, pl), "R2", "presence mid-byte", pd * 1000 + pl, T_PDLY * 1000 + T_PP);
        write_byte(8'h99);
        read_byte(got);
        chk(got == 8'h55, "R5", "ack after mid-byte reset", got, 8'h55);
        chk(wr_drive == 0, "R9", "drive during write slots (end)", wr_drive, 0);

        finish_run();
    end
endmodule